// File: doc/BRIEF.md
# 68000 Bus Memory and Port Select Decoder

This block watches one 68000-style asynchronous bus cycle per address strobe. It turns the address, direction and data-strobe lines into registered, active-low chip selects for the board's memories and I/O ports. The address space below the top address bit is cut into 64 KB segments by a 3-to-8 decode of A18:A16. Each segment feeds one destination: kernel ROM, kernel RAM (one 32K x 8 device per byte lane), personality ROM, address RAM, emulation RAM (split into two banks by A15), or the port block. Inside the port block, four separate decoders produce output-port and input-port selects for the high and low byte lanes.

Any access with the top address bit set, outside an interrupt acknowledge, is a self-test access. It suppresses every memory, port and write-strobe output. A read of this kind raises a self-test output enable. A write raises a self-test latch enable for exactly one clock. All outputs are registered: each one reflects the inputs sampled at the previous rising clock edge. Between bus cycles and during reset, all outputs are inactive.

Top module: `bus_select_decoder`

## Requirements
- R1: When the address strobe is active, the top address bit is 0 and interrupt acknowledge is low, A18:A16 picks the destination: 0 kernel ROM, 1 kernel RAM, 2 personality ROM, 3 address RAM, 4 emulation RAM, 5 port block, 6 and 7 none. Kernel ROM, personality ROM and address RAM use a single select each. Kernel RAM has a high-lane select, active when UDS- is low, and a low-lane select, active when LDS- is low.
- R2: An emulation RAM access asserts bank A when A15 is 0 and bank B when A15 is 1. The two banks are never asserted together.
- R3: On a write (rw = 0) with the top address bit 0 and no interrupt acknowledge, the upper strobe is asserted when UDS- is low and the lower strobe when LDS- is low. A word write asserts both. A read asserts neither.
- R4: A write in the port block asserts output-port select number A3:A1: the high-lane set when UDS- is low and the low-lane set when LDS- is low.
- R5: A read in the port block asserts input-port select number A3:A1, with lanes qualified by UDS- and LDS- in the same way.
- R6: A self-test access (top address bit 1, interrupt acknowledge low, strobe active) deasserts every memory, port and write-strobe output. On a read (rw = 1) it asserts the self-test output enable.
- R7: A self-test write with at least one data strobe low raises the active-high latch enable for exactly one clock per address-strobe cycle, however long the cycle lasts.
- R8: During reset, and in the cycle after the address strobe was sampled inactive, every select and strobe is inactive. Each output follows the inputs sampled at the previous rising edge.
- R9: While interrupt acknowledge is high, no select, strobe, output enable or latch enable is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | ADDR_W-1 | Address bus A[ADDR_W-1:1] |
| as_n_i | input | 1 | Address strobe, active low |
| rw_i | input | 1 | 1 = read, 0 = write |
| uds_n_i | input | 1 | Upper data strobe, active low |
| lds_n_i | input | 1 | Lower data strobe, active low |
| iack_i | input | 1 | Interrupt acknowledge cycle, active high |
| krom_sel_n_o | output | 1 | Kernel ROM select |
| kram_hi_sel_n_o | output | 1 | Kernel RAM high-lane select |
| kram_lo_sel_n_o | output | 1 | Kernel RAM low-lane select |
| prom_sel_n_o | output | 1 | Personality ROM select |
| aram_sel_n_o | output | 1 | Address RAM select |
| eram_a_sel_n_o | output | 1 | Emulation RAM bank A select |
| eram_b_sel_n_o | output | 1 | Emulation RAM bank B select |
| wu_n_o | output | 1 | Upper byte write strobe |
| wl_n_o | output | 1 | Lower byte write strobe |
| out_hi_sel_n_o | output | NPORT | High-lane output port selects |
| out_lo_sel_n_o | output | NPORT | Low-lane output port selects |
| in_hi_sel_n_o | output | NPORT | High-lane input port selects |
| in_lo_sel_n_o | output | NPORT | Low-lane input port selects |
| st_oe_n_o | output | 1 | Self-test output enable, active low |
| st_le_o | output | 1 | Self-test latch enable pulse, active high |

## Verification
The assertions check, on every cycle, the properties that hold whatever the address:
- outputs are quiet after an idle strobe or during an interrupt acknowledge;
- at most one destination is selected at a time;
- the emulation RAM bank matches the A15 just sampled;
- a write strobe appears only after a write with the matching data strobe;
- the latch enable never lasts two clocks and the output enable follows only a read.

Only the bench's scenarios show that every segment and port number reaches exactly the right output. They also show that lane qualification is correct for byte and word cycles, and that a long self-test write yields one pulse while back-to-back writes yield one pulse each.

// File: rtl/bsd_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the bus select decoder.
// Assumes a 3-bit segment code taken from the address bus.
package bsd_pkg;
    localparam int SEG_BITS = 3;
    localparam int NSEG     = 1 << SEG_BITS;

    // Segment code to destination map; codes 6 and 7 select nothing.
    typedef enum logic [SEG_BITS-1:0] {
        SEG_KROM  = 3'd0,
        SEG_KRAM  = 3'd1,
        SEG_PROM  = 3'd2,
        SEG_ARAM  = 3'd3,
        SEG_ERAM  = 3'd4,
        SEG_PORT  = 3'd5,
        SEG_SPR6  = 3'd6,
        SEG_SPR7  = 3'd7
    } seg_e;

    // Index of each port decoder in the port decoder array.
    localparam int PDEC_OUT_HI = 0;
    localparam int PDEC_OUT_LO = 1;
    localparam int PDEC_IN_HI  = 2;
    localparam int PDEC_IN_LO  = 3;
    localparam int NPDEC       = 4;
endpackage

// File: rtl/bsd_onehot_dec.sv
`timescale 1ns/1ps
// Enabled binary-to-one-hot decoder with active-low outputs.
// Assumes: code_i is stable while en_i is high; at most one output is low.
module bsd_onehot_dec #(
    parameter int IN_W = 3,
    localparam int OUT_N = 1 << IN_W
) (
    input  logic              en_i,
    input  logic [IN_W-1:0]   code_i,
    output logic [OUT_N-1:0]  sel_n_o
);
    // One comparator per output line.
    for (genvar g = 0; g < OUT_N; g++) begin : g_line
        assign sel_n_o[g] = ~(en_i && (code_i == IN_W'(g)));
    end
endmodule

// File: rtl/bsd_lane_strobes.sv
`timescale 1ns/1ps
// Byte-lane qualifier: splits an enabled bus cycle into read and write
// enables per data lane. Assumes active-low data strobes and rw = 1 for read.
module bsd_lane_strobes (
    input  logic en_i,
    input  logic rw_i,
    input  logic uds_n_i,
    input  logic lds_n_i,
    output logic wr_hi_o,
    output logic wr_lo_o,
    output logic rd_hi_o,
    output logic rd_lo_o
);
    logic hi_act;
    logic lo_act;

    // Lane activity from the data strobes, gated by the cycle enable.
    always_comb begin
        hi_act  = en_i && !uds_n_i;
        lo_act  = en_i && !lds_n_i;
        wr_hi_o = hi_act && !rw_i;
        wr_lo_o = lo_act && !rw_i;
        rd_hi_o = hi_act && rw_i;
        rd_lo_o = lo_act && rw_i;
    end
endmodule

// File: rtl/bsd_selftest.sv
`timescale 1ns/1ps
// Self-test window detector. An access with the top address bit set,
// outside interrupt acknowledge, is a self-test access. Reads give a
// combinational output enable; writes give a one-clock latch-enable pulse
// per address-strobe cycle. Assumes synchronous active-low reset.
module bsd_selftest (
    input  logic clk,
    input  logic rst_n,
    input  logic as_n_i,
    input  logic iack_i,
    input  logic top_bit_i,
    input  logic rw_i,
    input  logic ds_any_i,
    output logic hit_o,
    output logic oe_o,
    output logic le_q_o
);
    logic wr_req;
    logic fired_q;

    // Classify the current cycle.
    always_comb begin
        hit_o  = !as_n_i && !iack_i && top_bit_i;
        oe_o   = hit_o && rw_i;
        wr_req = hit_o && !rw_i && ds_any_i;
    end

    // One pulse per strobe cycle; the fired flag rearms when AS- goes idle.
    always_ff @(posedge clk) begin
        if (!rst_n || as_n_i) begin
            le_q_o  <= 1'b0;
            fired_q <= 1'b0;
        end else begin
            le_q_o <= wr_req && !fired_q;
            if (wr_req) begin
                fired_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/bus_select_decoder.sv
`timescale 1ns/1ps
// Memory and port select decoder for a 68000-style bus.
// Segments of 64 KB are decoded from A[SEG_LO+2:SEG_LO], banks of emulation
// RAM from A[BANK_BIT], port numbers from A[PORT_LO+PORT_BITS-1:PORT_LO].
// The top address bit opens the self-test window. All outputs are registered
// and reflect the inputs sampled at the previous rising edge.
module bus_select_decoder #(
    parameter int ADDR_W    = 24,
    parameter int SEG_LO    = 16,
    parameter int BANK_BIT  = 15,
    parameter int PORT_LO   = 1,
    parameter int PORT_BITS = 3,
    localparam int NPORT    = 1 << PORT_BITS,
    localparam int ST_BIT   = ADDR_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:1] addr_i,
    input  logic              as_n_i,
    input  logic              rw_i,
    input  logic              uds_n_i,
    input  logic              lds_n_i,
    input  logic              iack_i,
    output logic              krom_sel_n_o,
    output logic              kram_hi_sel_n_o,
    output logic              kram_lo_sel_n_o,
    output logic              prom_sel_n_o,
    output logic              aram_sel_n_o,
    output logic              eram_a_sel_n_o,
    output logic              eram_b_sel_n_o,
    output logic              wu_n_o,
    output logic              wl_n_o,
    output logic [NPORT-1:0]  out_hi_sel_n_o,
    output logic [NPORT-1:0]  out_lo_sel_n_o,
    output logic [NPORT-1:0]  in_hi_sel_n_o,
    output logic [NPORT-1:0]  in_lo_sel_n_o,
    output logic              st_oe_n_o,
    output logic              st_le_o
);
    import bsd_pkg::*;

    logic                             mem_ok;
    logic [NSEG-1:0]                  seg_n;
    logic                             wr_hi, wr_lo, rd_hi, rd_lo;
    logic                             st_hit, st_oe, st_le;
    logic                             port_en;
    logic [NPDEC-1:0]                 pdec_en;
    logic [NPDEC-1:0][NPORT-1:0]      pdec_n;
    logic                             unused_addr;

    logic krom_nx, kram_hi_nx, kram_lo_nx, prom_nx, aram_nx;
    logic eram_a_nx, eram_b_nx, wu_nx, wl_nx;

    // Address bits outside the decoded fields are not used here.
    assign unused_addr = ^addr_i;

    // Internal (non-self-test) access qualifier.
    assign mem_ok = !as_n_i && !iack_i && !addr_i[ST_BIT];

    // Segment decoder over the 64 KB segment code.
    bsd_onehot_dec #(.IN_W(SEG_BITS)) u_seg_dec (
        .en_i    (mem_ok),
        .code_i  (addr_i[SEG_LO+SEG_BITS-1:SEG_LO]),
        .sel_n_o (seg_n)
    );

    // Byte-lane read and write enables for internal accesses.
    bsd_lane_strobes u_lanes (
        .en_i    (mem_ok),
        .rw_i    (rw_i),
        .uds_n_i (uds_n_i),
        .lds_n_i (lds_n_i),
        .wr_hi_o (wr_hi),
        .wr_lo_o (wr_lo),
        .rd_hi_o (rd_hi),
        .rd_lo_o (rd_lo)
    );

    // Self-test window and latch-enable pulse.
    bsd_selftest u_selftest (
        .clk       (clk),
        .rst_n     (rst_n),
        .as_n_i    (as_n_i),
        .iack_i    (iack_i),
        .top_bit_i (addr_i[ST_BIT]),
        .rw_i      (rw_i),
        .ds_any_i  (!uds_n_i || !lds_n_i),
        .hit_o     (st_hit),
        .oe_o      (st_oe),
        .le_q_o    (st_le)
    );

    // Port decoder enables, one per direction and lane.
    always_comb begin
        port_en              = !seg_n[SEG_PORT];
        pdec_en[PDEC_OUT_HI] = port_en && wr_hi;
        pdec_en[PDEC_OUT_LO] = port_en && wr_lo;
        pdec_en[PDEC_IN_HI]  = port_en && rd_hi;
        pdec_en[PDEC_IN_LO]  = port_en && rd_lo;
    end

    // Four separate port decoders sharing the port-number field.
    for (genvar p = 0; p < NPDEC; p++) begin : g_pdec
        bsd_onehot_dec #(.IN_W(PORT_BITS)) u_pdec (
            .en_i    (pdec_en[p]),
            .code_i  (addr_i[PORT_LO+PORT_BITS-1:PORT_LO]),
            .sel_n_o (pdec_n[p])
        );
    end

    // Next-state values of the memory selects and write strobes.
    always_comb begin
        krom_nx    = seg_n[SEG_KROM];
        kram_hi_nx = seg_n[SEG_KRAM] || uds_n_i;
        kram_lo_nx = seg_n[SEG_KRAM] || lds_n_i;
        prom_nx    = seg_n[SEG_PROM];
        aram_nx    = seg_n[SEG_ARAM];
        eram_a_nx  = seg_n[SEG_ERAM] ||  addr_i[BANK_BIT];
        eram_b_nx  = seg_n[SEG_ERAM] || !addr_i[BANK_BIT];
        wu_nx      = !wr_hi;
        wl_nx      = !wr_lo;
    end

    // Output register stage; reset and idle strobe leave everything inactive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            krom_sel_n_o    <= 1'b1;
            kram_hi_sel_n_o <= 1'b1;
            kram_lo_sel_n_o <= 1'b1;
            prom_sel_n_o    <= 1'b1;
            aram_sel_n_o    <= 1'b1;
            eram_a_sel_n_o  <= 1'b1;
            eram_b_sel_n_o  <= 1'b1;
            wu_n_o          <= 1'b1;
            wl_n_o          <= 1'b1;
            out_hi_sel_n_o  <= '1;
            out_lo_sel_n_o  <= '1;
            in_hi_sel_n_o   <= '1;
            in_lo_sel_n_o   <= '1;
            st_oe_n_o       <= 1'b1;
        end else begin
            krom_sel_n_o    <= krom_nx;
            kram_hi_sel_n_o <= kram_hi_nx;
            kram_lo_sel_n_o <= kram_lo_nx;
            prom_sel_n_o    <= prom_nx;
            aram_sel_n_o    <= aram_nx;
            eram_a_sel_n_o  <= eram_a_nx;
            eram_b_sel_n_o  <= eram_b_nx;
            wu_n_o          <= wu_nx;
            wl_n_o          <= wl_nx;
            out_hi_sel_n_o  <= pdec_n[PDEC_OUT_HI];
            out_lo_sel_n_o  <= pdec_n[PDEC_OUT_LO];
            in_hi_sel_n_o   <= pdec_n[PDEC_IN_HI];
            in_lo_sel_n_o   <= pdec_n[PDEC_IN_LO];
            st_oe_n_o       <= !st_oe;
        end
    end

    // Latch enable is already registered inside the self-test unit.
    assign st_le_o = st_le;

    // The hit flag is used only for checking consistency with the OE.
    logic unused_hit;
    assign unused_hit = st_hit;
endmodule

// File: rtl/bsd_checker.sv
`timescale 1ns/1ps
// Property checker for bus_select_decoder, attached by bind.
module bsd_checker #(
    parameter int ADDR_W    = 24,
    parameter int BANK_BIT  = 15,
    parameter int PORT_BITS = 3,
    localparam int NPORT    = 1 << PORT_BITS
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:1] addr_i,
    input logic              as_n_i,
    input logic              rw_i,
    input logic              uds_n_i,
    input logic              lds_n_i,
    input logic              iack_i,
    input logic              krom_sel_n_o,
    input logic              kram_hi_sel_n_o,
    input logic              kram_lo_sel_n_o,
    input logic              prom_sel_n_o,
    input logic              aram_sel_n_o,
    input logic              eram_a_sel_n_o,
    input logic              eram_b_sel_n_o,
    input logic              wu_n_o,
    input logic              wl_n_o,
    input logic [NPORT-1:0]  out_hi_sel_n_o,
    input logic [NPORT-1:0]  out_lo_sel_n_o,
    input logic [NPORT-1:0]  in_hi_sel_n_o,
    input logic [NPORT-1:0]  in_lo_sel_n_o,
    input logic              st_oe_n_o,
    input logic              st_le_o
);
    logic all_quiet;
    logic port_any;

    always_comb begin
        port_any  = !(&out_hi_sel_n_o && &out_lo_sel_n_o &&
                      &in_hi_sel_n_o && &in_lo_sel_n_o);
        all_quiet = krom_sel_n_o && kram_hi_sel_n_o && kram_lo_sel_n_o &&
                    prom_sel_n_o && aram_sel_n_o && eram_a_sel_n_o &&
                    eram_b_sel_n_o && wu_n_o && wl_n_o && !port_any &&
                    st_oe_n_o && !st_le_o;
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        as_n_i |=> all_quiet); // R8
    AST_IACK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        iack_i |=> all_quiet); // R9
    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!krom_sel_n_o, !(kram_hi_sel_n_o && kram_lo_sel_n_o),
                  !prom_sel_n_o, !aram_sel_n_o, !eram_a_sel_n_o,
                  !eram_b_sel_n_o, port_any, !st_oe_n_o})); // R1
    AST_BANK_A_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !eram_a_sel_n_o |-> !$past(addr_i[BANK_BIT])); // R2
    AST_BANK_B_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !eram_b_sel_n_o |-> $past(addr_i[BANK_BIT])); // R2
    AST_WU_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wu_n_o |-> $past(!rw_i && !uds_n_i && !as_n_i)); // R3
    AST_WL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wl_n_o |-> $past(!rw_i && !lds_n_i && !as_n_i)); // R3
    AST_OUTPORT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~out_hi_sel_n_o) && $onehot0(~out_lo_sel_n_o)); // R4
    AST_INPORT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !(&in_hi_sel_n_o && &in_lo_sel_n_o) |-> $past(rw_i)); // R5
    AST_OE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !st_oe_n_o |-> $past(rw_i && addr_i[ADDR_W-1] && !iack_i)); // R6
    AST_LE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_le_o |=> !st_le_o); // R7
    AST_LE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        st_le_o |-> $past(!rw_i && addr_i[ADDR_W-1]) && wu_n_o && wl_n_o); // R7
endmodule

bind bus_select_decoder bsd_checker #(
    .ADDR_W    (ADDR_W),
    .BANK_BIT  (BANK_BIT),
    .PORT_BITS (PORT_BITS)
) u_chk (.*);

// File: tb/bus_select_decoder_bench.sv
`timescale 1ns/1ps
// Self-checking bench: directed corner cases then seeded random bus cycles.
module bus_select_decoder_bench;
    localparam int AW = 24;
    localparam int NP = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:1] addr = '0;
    logic          as_n = 1'b1, rw = 1'b1, uds_n = 1'b1, lds_n = 1'b1, iack = 1'b0;

    logic krom_n, kram_hi_n, kram_lo_n, prom_n, aram_n, era_n, erb_n, wu_n, wl_n;
    logic [NP-1:0] oh_n, ol_n, ih_n, il_n;
    logic st_oe_n, st_le;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Bench model state and expected outputs.
    bit m_fired = 1'b0;
    logic [4:0]  e_r1;
    logic [1:0]  e_r2, e_r3;
    logic [15:0] e_r4, e_r5;
    logic        e_r6, e_r7;
    logic        was_idle, was_iack;

    always #2.5 clk = ~clk;

    bus_select_decoder u_bus_select_decoder (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .as_n_i(as_n), .rw_i(rw),
        .uds_n_i(uds_n), .lds_n_i(lds_n), .iack_i(iack),
        .krom_sel_n_o(krom_n), .kram_hi_sel_n_o(kram_hi_n),
        .kram_lo_sel_n_o(kram_lo_n), .prom_sel_n_o(prom_n),
        .aram_sel_n_o(aram_n), .eram_a_sel_n_o(era_n), .eram_b_sel_n_o(erb_n),
        .wu_n_o(wu_n), .wl_n_o(wl_n), .out_hi_sel_n_o(oh_n),
        .out_lo_sel_n_o(ol_n), .in_hi_sel_n_o(ih_n), .in_lo_sel_n_o(il_n),
        .st_oe_n_o(st_oe_n), .st_le_o(st_le)
    );

    // Compare one output group and report a mismatch.
    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Expected outputs from the requirements, for inputs sampled at this edge.
    task automatic model();
        bit ok, mem, st, port;
        logic [2:0] seg;
        logic [2:0] pn;
        ok  = rst_n && !as_n && !iack;
        mem = ok && !addr[AW-1];
        st  = ok && addr[AW-1];
        seg = addr[18:16];
        pn  = addr[3:1];
        port = mem && seg == 3'd5;
        e_r1 = {!(mem && seg == 3'd0), !(mem && seg == 3'd1 && !uds_n),
                !(mem && seg == 3'd1 && !lds_n), !(mem && seg == 3'd2),
                !(mem && seg == 3'd3)};
        e_r2 = {!(mem && seg == 3'd4 && !addr[15]), !(mem && seg == 3'd4 && addr[15])};
        e_r3 = {!(mem && !rw && !uds_n), !(mem && !rw && !lds_n)};
        e_r4 = '1;
        e_r5 = '1;
        if (port && !rw && !uds_n) e_r4[8 + pn] = 1'b0;
        if (port && !rw && !lds_n) e_r4[pn]     = 1'b0;
        if (port && rw && !uds_n)  e_r5[8 + pn] = 1'b0;
        if (port && rw && !lds_n)  e_r5[pn]     = 1'b0;
        e_r6 = !(st && rw);
        if (!rst_n || as_n) begin
            e_r7 = 1'b0;
            m_fired = 1'b0;
        end else begin
            e_r7 = st && !rw && (!uds_n || !lds_n) && !m_fired;
            if (st && !rw && (!uds_n || !lds_n)) m_fired = 1'b1;
        end
        was_idle = !rst_n || as_n;
        was_iack = rst_n && iack;
    endtask

    // One clock: inputs already driven; model at the edge, compare at negedge.
    task automatic step();
        @(posedge clk);
        model();
        @(negedge clk);
        chk("R1 memory selects", {11'h0, krom_n, kram_hi_n, kram_lo_n, prom_n, aram_n}, {11'h0, e_r1});
        chk("R2 eram bank", {14'h0, era_n, erb_n}, {14'h0, e_r2});
        chk("R3 write strobes", {14'h0, wu_n, wl_n}, {14'h0, e_r3});
        chk("R4 output ports", {oh_n, ol_n}, e_r4);
        chk("R5 input ports", {ih_n, il_n}, e_r5);
        chk("R6 self-test oe", {15'h0, st_oe_n}, {15'h0, e_r6});
        chk("R7 latch enable", {15'h0, st_le}, {15'h0, e_r7});
        if (was_idle || was_iack) begin
            chk(was_idle ? "R8 idle quiet" : "R9 iack quiet",
                {krom_n & kram_hi_n & kram_lo_n & prom_n & aram_n & era_n & erb_n,
                 wu_n & wl_n, &{oh_n, ol_n, ih_n, il_n}, st_oe_n, !st_le, 11'h0},
                {5'b11111, 11'h0});
        end
    endtask

    // Drive one bus cycle held for n clocks, then one idle clock.
    task automatic cyc(input logic [AW-1:1] a, input logic r, input logic u,
                       input logic l, input logic ia, input int n);
        addr = a; rw = r; uds_n = u; lds_n = l; iack = ia; as_n = 1'b0;
        for (int i = 0; i < n; i++) step();
        as_n = 1'b1;
        step();
    endtask

    function automatic logic [AW-1:1] mk(input logic top, input logic [2:0] seg,
                                        input logic b15, input logic [2:0] pn);
        logic [AW-1:0] a;
        a = AW'($urandom);
        a[AW-1] = top;
        a[18:16] = seg;
        a[15] = b15;
        a[3:1] = pn;
        return a[AW-1:1];
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(150000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        // R8: reset with an active strobe keeps everything quiet.
        addr = mk(1'b0, 3'd1, 1'b0, 3'd2); as_n = 1'b0; rw = 1'b0; uds_n = 1'b0; lds_n = 1'b0;
        repeat (3) step();
        as_n = 1'b1;
        rst_n = 1'b1;
        step();
        // Directed corners.
        cyc(mk(1'b0, 3'd1, 1'b0, 3'd0), 1'b0, 1'b0, 1'b0, 1'b0, 2); // R3 word write kram
        cyc(mk(1'b0, 3'd1, 1'b0, 3'd0), 1'b0, 1'b0, 1'b1, 1'b0, 1); // R1 upper byte
        cyc(mk(1'b0, 3'd1, 1'b0, 3'd0), 1'b1, 1'b1, 1'b0, 1'b0, 1); // R1 lower read
        cyc(mk(1'b0, 3'd4, 1'b0, 3'd0), 1'b1, 1'b0, 1'b0, 1'b0, 1); // R2 bank A
        cyc(mk(1'b0, 3'd4, 1'b1, 3'd0), 1'b0, 1'b0, 1'b0, 1'b0, 1); // R2 bank B
        cyc(mk(1'b0, 3'd5, 1'b0, 3'd7), 1'b0, 1'b0, 1'b1, 1'b0, 1); // R4 port 7 high
        cyc(mk(1'b0, 3'd5, 1'b0, 3'd0), 1'b0, 1'b1, 1'b0, 1'b0, 1); // R4 port 0 low
        cyc(mk(1'b0, 3'd5, 1'b1, 3'd3), 1'b1, 1'b0, 1'b0, 1'b0, 1); // R5 word read
        cyc(mk(1'b0, 3'd6, 1'b0, 3'd3), 1'b0, 1'b0, 1'b0, 1'b0, 1); // R1 spare segment
        cyc(mk(1'b1, 3'd1, 1'b0, 3'd0), 1'b0, 1'b0, 1'b0, 1'b0, 5); // R7 long write, one pulse
        cyc(mk(1'b1, 3'd5, 1'b0, 3'd1), 1'b0, 1'b1, 1'b1, 1'b0, 2); // R7 no strobe, no pulse
        cyc(mk(1'b1, 3'd0, 1'b0, 3'd1), 1'b1, 1'b0, 1'b0, 1'b0, 3); // R6 self-test read
        cyc(mk(1'b1, 3'd1, 1'b0, 3'd0), 1'b1, 1'b0, 1'b0, 1'b1, 2); // R9 iack, top bit set
        cyc(mk(1'b0, 3'd5, 1'b0, 3'd2), 1'b0, 1'b0, 1'b0, 1'b1, 2); // R9 iack, low address
        // Back-to-back self-test writes: one pulse each (R7).
        cyc(mk(1'b1, 3'd2, 1'b0, 3'd0), 1'b0, 1'b0, 1'b1, 1'b0, 2);
        cyc(mk(1'b1, 3'd2, 1'b0, 3'd0), 1'b0, 1'b1, 1'b0, 1'b0, 2);
        // Seeded random cycles.
        for (int t = 0; t < 3000; t++) begin
            logic top;
            top = ($urandom % 10) < 3;
            addr = mk(top, 3'($urandom), 1'($urandom), 3'($urandom));
            rw = 1'($urandom);
            uds_n = 1'($urandom);
            lds_n = 1'($urandom);
            iack = ($urandom % 10) == 0;
            as_n = 1'b0;
            for (int i = 0; i < 1 + int'($urandom % 4); i++) step();
            if ($urandom % 3 != 0) begin
                as_n = 1'b1;
                step();
            end
        end
        // Reset in mid-cycle returns to quiet (R8).
        addr = mk(1'b0, 3'd4, 1'b1, 3'd0); as_n = 1'b0; rw = 1'b0; uds_n = 1'b0; iack = 1'b0;
        step();
        rst_n = 1'b0;
        step();
        step();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule